// File: doc/BRIEF.md
# Programmable RGB Color Matrix Converter

This block converts a stream of 24-bit RGB pixels, one byte per color, into 16-bit 5-6-5 RGB words. Each output channel is a weighted sum of the three input channels plus a signed offset. The three output channels use nine coefficients and three offsets in total. All twelve values are signed fixed-point numbers that software can rewrite at runtime. Every coefficient and every offset sits in its own 32-bit register, which holds a two's complement number with 8 fraction bits. A value of 1.5 is written as 0x00000180 and -1.0 as 0xFFFFFF00. The offsets let software raise or lower each color's level on its own.

Software writes go into a shadow set of registers. The datapath reads a separate active set. The shadow set is copied into the active set on a start-of-frame pulse, and on every cycle while the block is stopped, so no frame is ever computed with a mix of old and new values.

A run bit starts and stops the block. Clearing it makes the block refuse new pixels while the pixels already inside drain out. A status bit then reports that the block is fully idle. Both streams use valid/ready handshakes, and the three-stage datapath holds its contents while the output is not ready.

Top module: `rgb_matrix565`

## Requirements
- R1: After reset `m_valid` is 0 and the block is stopped (`s_ready` is 0, run bit is 0). The coefficients reset to the identity matrix: registers 0, 4 and 8 read 0x00000100 and the other coefficients read 0. All offsets read 0.
- R2: Register addresses are laid out as follows.
  - Coefficient register 3k+j weights input channel j (0 = red from bits 23:16, 1 = green from 15:8, 2 = blue from 7:0) into output channel k.
  - Registers 9, 10 and 11 hold the red, green and blue offsets.
  - Register 12, bit 0, is the run bit.
  - Register 13, bit 0, is the halted status.
  - Reading registers 0 to 11 returns the last value written.
- R3: Each output channel equals floor((sum of coefficient×input + offset + 0x80) / 256). All values are 32-bit two's complement with 8 fraction bits, so the result rounds half up.
- R4: Each channel result saturates to the range 0..255 before packing.
- R5: The output word has red bits 7:3 of the result in bits 15:11, green bits 7:2 in bits 10:5, and blue bits 7:3 in bits 4:0.
- R6: With the output ready, a pixel accepted at one clock edge appears on `m_valid`/`m_pixel` after the second following edge. Pixels leave in the order they arrived.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_pixel` stays unchanged. When the pipeline is full, `s_ready` is 0.
- R8: While the run bit is 0, `s_ready` is 0 and no pixel is taken. Pixels already accepted still drain to the output, and then no further output appears.
- R9: The halted status reads 1 exactly when the run bit is 0 and no pixel remains in the pipeline.
- R10: A register write made while running does not affect pixels until a `frame_start` pulse. Pixels accepted after the pulse's clock edge use the new value. While stopped, writes reach the active set one cycle later.
- R11: Negative coefficients and offsets subtract from the channel sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block accepts a pixel this cycle |
| s_pixel | input | 24 | Input pixel: red 23:16, green 15:8, blue 7:0 |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_pixel | output | 16 | Packed 5-6-5 output pixel |
| frame_start | input | 1 | Start-of-frame pulse; copies shadow registers to the active set |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
A wrong active coefficient or offset shows up as a wrong `m_pixel` value two edges after the pixel is accepted. The frame-boundary tests catch a shadow copy that happens too early or too late on the first pixel after the write or after the pulse. A pipeline stage that loses its hold under backpressure shows up as a changed `m_pixel` during a stall, or as an output missing after the pipeline drains. A stale valid bit shows up as the halted status reading wrong, or as `m_valid` rising while the block is stopped.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCH      = 3;
  localparam int NCOEF    = 9;
  localparam int ADR_SUM0 = 9;
  localparam int ADR_CTRL = 12;
  localparam int ADR_STAT = 13;

  // Truncate three saturated 8-bit channels into a 5-6-5 word.
  function automatic logic [15:0] pack565(input logic [7:0] r,
                                          input logic [7:0] g,
                                          input logic [7:0] b);
    return {r[7:3], g[7:2], b[7:3]};
  endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
#(
  parameter int CW   = 32,
  parameter int FRAC = 8,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          frame_start,
  input  logic          pipe_empty,
  output logic          run,
  output logic          halted,
  output logic [CW-1:0] act_coef [NCOEF],
  output logic [CW-1:0] act_sum  [NCH]
);
  localparam logic [CW-1:0] ONE = CW'(1) << FRAC;

  logic [CW-1:0] sh_coef [NCOEF];
  logic [CW-1:0] sh_sum  [NCH];
  logic          run_q;
  logic          shadow_load;

  assign shadow_load = !run_q || frame_start;
  assign run         = run_q;
  assign halted      = !run_q && pipe_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) sh_coef[i] <= (i % 4 == 0) ? ONE : '0;
      for (int k = 0; k < NCH; k++)   sh_sum[k]  <= '0;
      run_q <= 1'b0;
    end else if (wr) begin
      for (int i = 0; i < NCOEF; i++)
        if (addr == AW'(i)) sh_coef[i] <= wdata;
      for (int k = 0; k < NCH; k++)
        if (addr == AW'(ADR_SUM0 + k)) sh_sum[k] <= wdata;
      if (addr == AW'(ADR_CTRL)) run_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) act_coef[i] <= (i % 4 == 0) ? ONE : '0;
      for (int k = 0; k < NCH; k++)   act_sum[k]  <= '0;
    end else if (shadow_load) begin
      for (int i = 0; i < NCOEF; i++) act_coef[i] <= sh_coef[i];
      for (int k = 0; k < NCH; k++)   act_sum[k]  <= sh_sum[k];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCOEF; i++)
      if (addr == AW'(i)) rdata = sh_coef[i];
    for (int k = 0; k < NCH; k++)
      if (addr == AW'(ADR_SUM0 + k)) rdata = sh_sum[k];
    if (addr == AW'(ADR_CTRL)) rdata = {{(CW-1){1'b0}}, run_q};
    if (addr == AW'(ADR_STAT)) rdata = {{(CW-1){1'b0}}, halted};
  end

  // R10: while running and no frame pulse, the active set does not move
  p_active_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !frame_start) |=> ($stable(act_coef[0]) && $stable(act_coef[4]) &&
                                 $stable(act_coef[8]) && $stable(act_sum[0]) &&
                                 $stable(act_sum[1]) && $stable(act_sum[2])));
endmodule

// File: rtl/csc_pipe.sv
module csc_pipe
  import csc_pkg::*;
#(
  parameter int CW   = 32,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] coef [NCOEF],
  input  logic [CW-1:0] summ [NCH],
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [23:0]   s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [15:0]   m_data,
  output logic          empty
);
  localparam int PW = CW + 9;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = SW'(255);
  localparam logic signed [SW-1:0] ZERO = '0;

  // signed coefficient times unsigned byte (zero-extended to 9 bits signed)
  function automatic logic signed [PW-1:0] mul(input logic [CW-1:0] c,
                                               input logic [7:0] x);
    logic signed [PW-1:0] a, b;
    a = {{(PW-CW){c[CW-1]}}, c};
    b = {{(PW-8){1'b0}}, x};
    return a * b;
  endfunction

  function automatic logic signed [SW-1:0] add4(input logic signed [PW-1:0] a,
                                                input logic signed [PW-1:0] b,
                                                input logic signed [PW-1:0] c,
                                                input logic [CW-1:0] s);
    logic signed [SW-1:0] ea, eb, ec, es;
    ea = {{(SW-PW){a[PW-1]}}, a};
    eb = {{(SW-PW){b[PW-1]}}, b};
    ec = {{(SW-PW){c[PW-1]}}, c};
    es = {{(SW-CW){s[CW-1]}}, s};
    return ea + eb + ec + es;
  endfunction

  function automatic logic [7:0] rnd_sat(input logic signed [SW-1:0] a);
    logic signed [SW-1:0] t;
    t = (a + HALF) >>> FRAC;
    if (t < ZERO) return 8'd0;
    if (t > MAXV) return 8'hFF;
    return t[7:0];
  endfunction

  logic       v1, v2, v3;
  logic       adv;
  logic       px_take;
  logic [7:0] px [NCH];
  logic [7:0] chan [NCH];

  assign adv     = !v3 || m_ready;
  assign s_ready = run && adv;
  assign px_take = s_valid && s_ready;
  assign px[0]   = s_data[23:16];
  assign px[1]   = s_data[15:8];
  assign px[2]   = s_data[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= px_take;
      v2 <= v1;
      v3 <= v2;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic signed [PW-1:0] p_a, p_b, p_c;
    logic [CW-1:0]        s_q;
    logic signed [SW-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_a   <= '0;
        p_b   <= '0;
        p_c   <= '0;
        s_q   <= '0;
        acc_q <= '0;
      end else if (adv) begin
        p_a   <= mul(coef[3*k],   px[0]);
        p_b   <= mul(coef[3*k+1], px[1]);
        p_c   <= mul(coef[3*k+2], px[2]);
        s_q   <= summ[k];
        acc_q <= add4(p_a, p_b, p_c, s_q);
      end
    end
    assign chan[k] = rnd_sat(acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   m_data <= '0;
    else if (adv) m_data <= pack565(chan[0], chan[1], chan[2]);
  end

  assign m_valid = v3;
  assign empty   = !v1 && !v2 && !v3;

  // R7: a stalled output holds its pixel
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R8: no intake while stopped
  p_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !px_take);
  // R8: a stopped, empty pipeline produces no output next cycle
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && empty) |=> !m_valid);
endmodule

// File: rtl/rgb_matrix565.sv
module rgb_matrix565
  import csc_pkg::*;
#(
  parameter int CW   = 32,
  parameter int FRAC = 8,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [23:0]   s_pixel,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [15:0]   m_pixel,
  input  logic          frame_start,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata
);
  logic          run;
  logic          halted;
  logic          pipe_empty;
  logic [CW-1:0] act_coef [NCOEF];
  logic [CW-1:0] act_sum  [NCH];

  csc_regs #(.CW(CW), .FRAC(FRAC), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .frame_start(frame_start),
    .pipe_empty (pipe_empty),
    .run        (run),
    .halted     (halted),
    .act_coef   (act_coef),
    .act_sum    (act_sum)
  );

  csc_pipe #(.CW(CW), .FRAC(FRAC)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .coef   (act_coef),
    .summ   (act_sum),
    .s_valid(s_valid),
    .s_ready(s_ready),
    .s_data (s_pixel),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_data (m_pixel),
    .empty  (pipe_empty)
  );

  // R9: halted implies nothing left to emit or accept
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!m_valid && !s_ready));
endmodule

// File: tb/tb_rgb_matrix565.sv
module tb_rgb_matrix565;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pixel = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_pixel;
  logic        frame_start = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] got [256];
  int got_n = 0;
  longint sh_c [9];
  longint sh_s [3];
  longint ac_c [9];
  longint ac_s [3];

  always #4 clk = ~clk;

  rgb_matrix565 dut (.*);

  // pixel {in, expected} under the identity matrix
  localparam logic [39:0] VEC [7] = '{
    {24'h000000, 16'h0000}, {24'hFFFFFF, 16'hFFFF}, {24'hFF0000, 16'hF800},
    {24'h00FF00, 16'h07E0}, {24'h0000FF, 16'h001F}, {24'h123456, 16'h11AA},
    {24'h808080, 16'h8410}};

  always @(negedge clk)
    if (rst_n && m_valid && m_ready) begin
      got[got_n[7:0]] = m_pixel;
      got_n++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
    if (a < 9) sh_c[a] = longint'($signed(d));
    else if (a < 12) sh_s[a-9] = longint'($signed(d));
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic sync();
    for (int i = 0; i < 9; i++) ac_c[i] = sh_c[i];
    for (int k = 0; k < 3; k++) ac_s[k] = sh_s[k];
  endtask

  task automatic send(input logic [23:0] p);
    bit ok;
    s_valid = 1'b1; s_pixel = p;
    forever begin
      @(negedge clk); ok = s_ready;
      @(posedge clk); #2;
      if (ok) break;
    end
    s_valid = 1'b0;
  endtask

  function automatic longint fdiv256(input longint x);
    if (x >= 0) return x / 256;
    return -((-x + 255) / 256);
  endfunction

  function automatic logic [15:0] model(input logic [23:0] p);
    longint in_v [3];
    longint res [3];
    in_v[0] = longint'(p[23:16]); in_v[1] = longint'(p[15:8]); in_v[2] = longint'(p[7:0]);
    for (int k = 0; k < 3; k++) begin
      longint s;
      s = ac_s[k];
      for (int j = 0; j < 3; j++) s += ac_c[3*k+j] * in_v[j];
      res[k] = fdiv256(s + 128);
      if (res[k] < 0) res[k] = 0;
      if (res[k] > 255) res[k] = 255;
    end
    return 16'((res[0] / 8) * 2048 + (res[1] / 4) * 32 + (res[2] / 8));
  endfunction

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] held, e1, e2, e3;
    int base;
    for (int i = 0; i < 9; i++) sh_c[i] = (i % 4 == 0) ? 256 : 0;
    for (int k = 0; k < 3; k++) sh_s[k] = 0;
    sync();
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
    chk(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
    rreg(0, rd);  chk(rd == 32'h100, "R1 coef0", rd, 32'h100);
    rreg(1, rd);  chk(rd == 32'h0, "R1 coef1", rd, 0);
    rreg(8, rd);  chk(rd == 32'h100, "R1 coef8", rd, 32'h100);
    rreg(10, rd); chk(rd == 32'h0, "R1 sum1", rd, 0);
    rreg(12, rd); chk(rd == 32'h0, "R1 run", rd, 0);
    rreg(13, rd); chk(rd == 32'h1, "R9 halted at reset", rd, 1);

    // R2 register readback
    wreg(5, 32'hFFFFFF00);
    rreg(5, rd);  chk(rd == 32'hFFFFFF00, "R2 readback coef5", rd, 32'hFFFFFF00);
    wreg(11, 32'h00000180);
    rreg(11, rd); chk(rd == 32'h180, "R2 readback sum2", rd, 32'h180);
    wreg(5, 32'h0); wreg(11, 32'h0);
    step(1); sync();

    // R8 run bit opens input
    wreg(12, 32'h1);
    #1 chk(s_ready == 1'b1, "R8 s_ready when running", s_ready, 1);

    // R3/R5 vector table under identity
    base = got_n;
    foreach (VEC[i]) send(VEC[i][39:16]);
    step(5);
    foreach (VEC[i])
      chk(got[(base + i) % 256] == VEC[i][15:0], "R5 table", got[(base + i) % 256], VEC[i][15:0]);

    // R6 latency
    send(24'hFF0000);
    chk(m_valid == 1'b0, "R6 edge0", m_valid, 0);
    step(1); chk(m_valid == 1'b0, "R6 edge1", m_valid, 0);
    step(1); chk(m_valid == 1'b1 && m_pixel == 16'hF800, "R6 edge2", m_pixel, 16'hF800);
    step(3);

    // R3/R11 mixing matrix with negative entries
    wreg(12, 32'h0);
    wreg(0, 32'h180); wreg(1, 32'hFFFFFF00); wreg(2, 32'h0); wreg(9, 32'h00000A00);
    wreg(3, 32'h40);  wreg(4, 32'h80);       wreg(5, 32'h20); wreg(10, 32'h0);
    wreg(6, 32'h0);   wreg(7, 32'h0);        wreg(8, 32'hC0); wreg(11, 32'hFFFFFF80);
    step(1); sync();
    wreg(12, 32'h1);
    base = got_n;
    send(24'h6428C8); send(24'h000000); send(24'h10F003);
    step(5);
    chk(got[base % 256] == 16'h7A32, "R11 mix literal", got[base % 256], 16'h7A32);
    chk(got[(base + 1) % 256] == model(24'h000000), "R11 offsets only", got[(base + 1) % 256], model(24'h000000));
    chk(got[(base + 2) % 256] == model(24'h10F003), "R3 mix model", got[(base + 2) % 256], model(24'h10F003));

    // R4 saturation both ways
    wreg(12, 32'h0);
    wreg(9, 32'hFFFED400); wreg(10, 32'h00012C00);
    step(1); sync();
    wreg(12, 32'h1);
    base = got_n;
    send(24'hFFFFFF);
    step(5);
    chk(got[base % 256][15:11] == 5'd0 && got[base % 256][10:5] == 6'd63,
        "R4 clamp", got[base % 256], model(24'hFFFFFF));

    // R10 shadow vs active while running
    wreg(12, 32'h0);
    for (int i = 0; i < 9; i++) wreg(4'(i), (i % 4 == 0) ? 32'h100 : 32'h0);
    for (int k = 0; k < 3; k++) wreg(4'(9 + k), 32'h0);
    step(1); sync();
    wreg(12, 32'h1);
    wreg(0, 32'h80);
    base = got_n;
    send(24'hC80000);
    frame_start = 1'b1; step(1); frame_start = 1'b0; sync();
    send(24'hC80000);
    step(5);
    chk(got[base % 256] == 16'hC800, "R10 before pulse", got[base % 256], 16'hC800);
    chk(got[(base + 1) % 256] == 16'h6000, "R10 after pulse", got[(base + 1) % 256], 16'h6000);

    // R7 backpressure
    m_ready = 1'b0;
    e1 = model(24'h0000FF); e2 = model(24'h00FF00); e3 = model(24'hFF0000);
    send(24'h0000FF); send(24'h00FF00); send(24'hFF0000);
    chk(m_valid == 1'b1 && m_pixel == e1, "R7 head pixel", m_pixel, e1);
    chk(s_ready == 1'b0, "R7 full blocks input", s_ready, 0);
    held = m_pixel;
    step(3);
    chk(m_valid == 1'b1 && m_pixel == held, "R7 held stable", m_pixel, held);

    // R8/R9 stop while full, then drain
    wreg(12, 32'h0);
    rreg(13, rd); chk(rd == 32'h0, "R9 not halted with data", rd, 0);
    base = got_n;
    m_ready = 1'b1;
    step(5);
    chk(got_n - base == 3, "R8 drained count", got_n - base, 3);
    chk(got[base % 256] == e1 && got[(base + 1) % 256] == e2 && got[(base + 2) % 256] == e3,
        "R6 drain order", got[(base + 2) % 256], e3);
    rreg(13, rd); chk(rd == 32'h1, "R9 halted after drain", rd, 1);
    s_valid = 1'b1; s_pixel = 24'hFFFFFF;
    step(6);
    s_valid = 1'b0;
    chk(got_n - base == 3 && m_valid == 1'b0, "R8 nothing taken while stopped", got_n - base, 3);

    done = 1;
    finish_up();
  end
endmodule